// File: doc/BRIEF.md
# LIN Header Identifier and Response Direction Controller

This block sits beside a LIN byte serializer and deals only with the identifier byte of a frame header. It keeps a stored identifier. When the node transmits a header, the block presents the byte to put on the bus. In protected mode that byte is the six identifier bits topped with two computed parity bits. In raw mode it is all eight stored bits, unchanged. When the node receives a header, the block loads the incoming byte into the stored identifier. In protected mode it also checks the two parity bits and latches a sticky error flag on a mismatch.

After every accepted header event, a small state machine turns the 2-bit node-action input into a single-cycle response enable. The enable either tells the node to transmit the response, to listen for it, or to stay out of it. The machine has four states:
- `S_IDLE`: no header event was accepted in the previous cycle.
- `S_PUB`: drives the send enable.
- `S_SUB`: drives the receive enable.
- `S_IGN`: drives neither enable.

From any state, an accepted header event moves the machine as follows:
- `T_PUB`: to `S_PUB` when the action is publish.
- `T_SUB`: to `S_SUB` when the action is subscribe and the header was clean.
- `T_IGN`: to `S_IGN` on an ignore action, or on a subscribe action whose received header failed parity.
- `T_REST`: to `S_IDLE` when no header event occurs.

Top module: `lin_id_ctrl`

## Requirements
- R1: After reset the stored identifier is 0x00, the error flag is 0, and both response enables are 0.
- R2: With `par_off`=0, `tx_byte` is {P1, P0, id[5:0]}, where P0 (bit 6) = id0^id1^id2^id4 and P1 (bit 7) = ~(id1^id3^id4^id5). Stored bits 7:6 have no effect on it.
- R3: With `par_off`=1, `tx_byte` equals all eight stored identifier bits.
- R4: A received identifier with `par_off`=0 stores {2'b00, rx_byte[5:0]} one cycle after `rx_strobe`, whatever its parity.
- R5: A received identifier with `par_off`=1 stores all eight bits of `rx_byte` and never raises the error flag.
- R6: With `par_off`=0, a received byte whose bits 7:6 differ from the parity computed per R2 sets `par_err` on the next edge. The flag then stays at 1 until `err_clr` is pulsed. If a set and a clear occur in the same cycle, the set wins.
- R7: Node action is encoded 00 = publish, 01 = subscribe, 10 and 11 = ignore. One cycle after an accepted header event (`tx_strobe`, or a taken `rx_strobe`) with action 00, `resp_send` is 1 for exactly one cycle.
- R8: One cycle after an accepted header event with action 01, `resp_recv` is 1 for one cycle, unless that event was a received header that failed parity.
- R9: With action 10 or 11, neither enable rises after a header event.
- R10: Priority rules for coinciding inputs:
  - When `tx_strobe` and `rx_strobe` coincide, the transmit wins: the received byte is discarded and cannot set the error flag.
  - A taken receive overrides `id_load` in the same cycle.
- R11: `id_load` writes `id_wdata` into the stored identifier on the next edge when no receive is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_off | input | 1 | 1 selects raw 8-bit identifier mode |
| node_act | input | 2 | Response action: 00 publish, 01 subscribe, 1x ignore |
| id_load | input | 1 | Write strobe for the stored identifier |
| id_wdata | input | 8 | Identifier value to store |
| tx_strobe | input | 1 | Header transmit event |
| rx_strobe | input | 1 | Header receive event |
| rx_byte | input | 8 | Received identifier byte |
| err_clr | input | 1 | Clears the parity error flag |
| tx_byte | output | 8 | Identifier byte to transmit |
| id_q | output | 8 | Stored identifier |
| par_err | output | 1 | Sticky identifier parity error |
| resp_send | output | 1 | One-cycle response transmit enable |
| resp_recv | output | 1 | One-cycle response receive enable |

## Verification
The embedded properties assume every input is a known 0 or 1 on each rising edge. They also assume `node_act` and `par_off` may change from cycle to cycle, so each property samples them at the same edge as the strobe it pairs them with. The stimulus drives every input only on the falling clock edge and starts from all zeros before reset is released. It deliberately includes coinciding strobes, simultaneous set and clear of the error flag, and both illegal action codes, so the priority rules are covered without breaking those assumptions.

// File: rtl/lin_id_pkg.sv
package lin_id_pkg;

    localparam int ID_W  = 8;
    localparam int KEY_W = 6;

    typedef enum logic [1:0] {
        ACT_PUB = 2'b00,
        ACT_SUB = 2'b01,
        ACT_IGN = 2'b10,
        ACT_RSV = 2'b11
    } node_act_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PUB,
        S_SUB,
        S_IGN
    } resp_state_e;

    // protection bits for a 6-bit key: {P1, P0}
    function automatic logic [1:0] prot_bits(input logic [KEY_W-1:0] k);
        logic p0, p1;
        p0 = k[0] ^ k[1] ^ k[2] ^ k[4];
        p1 = ~(k[1] ^ k[3] ^ k[4] ^ k[5]);
        return {p1, p0};
    endfunction

endpackage

// File: rtl/lin_id_parity.sv
module lin_id_parity
    import lin_id_pkg::*;
#(
    parameter int W = ID_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_off,
    input  logic [W-1:0] id_q,
    input  logic [W-1:0] rx_byte,
    output logic [W-1:0] tx_byte,
    output logic         rx_bad
);
    localparam int KW = KEY_W;

    logic [1:0] tx_prot;
    logic [1:0] rx_prot;

    always_comb begin
        tx_prot = prot_bits(id_q[KW-1:0]);
        rx_prot = prot_bits(rx_byte[KW-1:0]);
        tx_byte = par_off ? id_q : {tx_prot, id_q[KW-1:0]};
        rx_bad  = !par_off && (rx_byte[W-1:KW] != rx_prot);
    end

    // R5: raw mode never flags a received byte
    a_r5_raw_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        par_off |-> !rx_bad);

    // R3: raw mode passes the stored byte through
    a_r3_raw_tx: assert property (@(posedge clk) disable iff (!rst_n)
        par_off |-> tx_byte == id_q);

endmodule

// File: rtl/lin_id_store.sv
module lin_id_store
    import lin_id_pkg::*;
#(
    parameter int W = ID_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_off,
    input  logic         tx_strobe,
    input  logic         rx_strobe,
    input  logic         rx_bad,
    input  logic [W-1:0] rx_byte,
    input  logic         id_load,
    input  logic [W-1:0] id_wdata,
    input  logic         err_clr,
    output logic         rx_take,
    output logic [W-1:0] id_q,
    output logic         par_err
);
    localparam int KW = KEY_W;

    assign rx_take = rx_strobe && !tx_strobe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q    <= '0;
            par_err <= 1'b0;
        end else begin
            if (rx_take)
                id_q <= par_off ? rx_byte : {{(W-KW){1'b0}}, rx_byte[KW-1:0]};
            else if (id_load)
                id_q <= id_wdata;
            par_err <= (par_err && !err_clr) || (rx_take && rx_bad);
        end
    end

    // R4: protected receive clears the top bits
    a_r4_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take && !par_off |=> id_q[W-1:KW] == '0);

    // R6: flag is sticky without a clear
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        par_err && !err_clr |=> par_err);

    // R10: a transmit with no load leaves the identifier alone
    a_r10_tx_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe && !id_load |=> id_q == $past(id_q));

endmodule

// File: rtl/lin_resp_fsm.sv
module lin_resp_fsm
    import lin_id_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_evt,
    input  logic       hdr_bad,
    input  logic [1:0] node_act,
    output logic       resp_send,
    output logic       resp_recv
);
    resp_state_e state_q, state_d;
    node_act_e   act;

    assign act = node_act_e'(node_act);

    always_comb begin
        state_d = S_IDLE;
        if (hdr_evt) begin
            unique case (act)
                ACT_PUB: state_d = S_PUB;
                ACT_SUB: state_d = hdr_bad ? S_IGN : S_SUB;
                ACT_IGN: state_d = S_IGN;
                ACT_RSV: state_d = S_IGN;
                default: state_d = S_IGN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        resp_send = 1'b0;
        resp_recv = 1'b0;
        unique case (state_q)
            S_PUB:   resp_send = 1'b1;
            S_SUB:   resp_recv = 1'b1;
            S_IDLE:  ;
            S_IGN:   ;
            default: ;
        endcase
    end

    // R7: directions are exclusive
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_send, resp_recv}));

    // R7: publish after a header
    a_r7_pub: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_evt && node_act == 2'b00 |=> resp_send);

    // R8: receive enable only follows a clean subscribe header
    a_r8_sub_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_evt || hdr_bad |=> !resp_recv);

    // R9: ignore codes gate both directions
    a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_evt && node_act[1] |=> !resp_send && !resp_recv);

endmodule

// File: rtl/lin_id_ctrl.sv
module lin_id_ctrl
    import lin_id_pkg::*;
#(
    parameter int W = ID_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_off,
    input  logic [1:0]   node_act,
    input  logic         id_load,
    input  logic [W-1:0] id_wdata,
    input  logic         tx_strobe,
    input  logic         rx_strobe,
    input  logic [W-1:0] rx_byte,
    input  logic         err_clr,
    output logic [W-1:0] tx_byte,
    output logic [W-1:0] id_q,
    output logic         par_err,
    output logic         resp_send,
    output logic         resp_recv
);
    logic rx_bad;
    logic rx_take;
    logic hdr_evt;
    logic hdr_bad;

    lin_id_parity #(.W(W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_off (par_off),
        .id_q    (id_q),
        .rx_byte (rx_byte),
        .tx_byte (tx_byte),
        .rx_bad  (rx_bad)
    );

    lin_id_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_off   (par_off),
        .tx_strobe (tx_strobe),
        .rx_strobe (rx_strobe),
        .rx_bad    (rx_bad),
        .rx_byte   (rx_byte),
        .id_load   (id_load),
        .id_wdata  (id_wdata),
        .err_clr   (err_clr),
        .rx_take   (rx_take),
        .id_q      (id_q),
        .par_err   (par_err)
    );

    assign hdr_evt = tx_strobe || rx_take;
    assign hdr_bad = rx_take && rx_bad;

    lin_resp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_evt   (hdr_evt),
        .hdr_bad   (hdr_bad),
        .node_act  (node_act),
        .resp_send (resp_send),
        .resp_recv (resp_recv)
    );

    // R6: an accepted bad header raises the flag
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && !tx_strobe && !par_off && rx_bad |=> par_err);

    // R1: reset state observed on the first cycle out of reset
    a_r1_reset: assert property (@(posedge clk)
        $past(!rst_n) |-> id_q == '0 && !par_err && !resp_send && !resp_recv);

endmodule

// File: tb/lin_id_ctrl_bench.sv
module lin_id_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_off = 1'b0;
    logic [1:0] node_act = 2'b00;
    logic       id_load = 1'b0;
    logic [7:0] id_wdata = 8'h00;
    logic       tx_strobe = 1'b0;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       err_clr = 1'b0;
    logic [7:0] tx_byte, id_q;
    logic       par_err, resp_send, resp_recv;

    int n_run = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_id;
    logic       m_err, m_send, m_recv;

    always #2 clk = ~clk;

    lin_id_ctrl u_lin_id_ctrl (
        .clk(clk), .rst_n(rst_n), .par_off(par_off), .node_act(node_act),
        .id_load(id_load), .id_wdata(id_wdata), .tx_strobe(tx_strobe),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .err_clr(err_clr),
        .tx_byte(tx_byte), .id_q(id_q), .par_err(par_err),
        .resp_send(resp_send), .resp_recv(resp_recv)
    );

    function automatic logic [1:0] ref_prot(input logic [7:0] v);
        logic a, b;
        a = ^(v & 8'b0001_0111);
        b = ~(^(v & 8'b0011_1010));
        return {b, a};
    endfunction

    function automatic logic [7:0] ref_tx(input logic [7:0] v, input logic raw);
        if (raw) return v;
        return {ref_prot(v), v[5:0]};
    endfunction

    function automatic logic [7:0] good_rx(input logic [5:0] k);
        return {ref_prot({2'b00, k}), k};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic taken, bad, hdr;
        if (!rst_n) begin
            m_id = 8'h00; m_err = 1'b0; m_send = 1'b0; m_recv = 1'b0;
            return;
        end
        taken = rx_strobe && !tx_strobe;
        bad   = taken && !par_off && (rx_byte[7:6] != ref_prot(rx_byte));
        hdr   = tx_strobe || taken;
        m_send = hdr && node_act == 2'b00;
        m_recv = hdr && node_act == 2'b01 && !bad;
        m_err  = (m_err && !err_clr) || bad;
        if (taken) m_id = par_off ? rx_byte : {2'b00, rx_byte[5:0]};
        else if (id_load) m_id = id_wdata;
    endtask

    task automatic compare_all();
        check("R4 R5 R10 R11 id_q", id_q, m_id);
        check("R2 R3 tx_byte", tx_byte, ref_tx(m_id, par_off));
        check("R6 par_err", {7'd0, par_err}, {7'd0, m_err});
        check("R7 R9 resp_send", {7'd0, resp_send}, {7'd0, m_send});
        check("R8 R9 resp_recv", {7'd0, resp_recv}, {7'd0, m_recv});
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        tx_strobe = 1'b0; rx_strobe = 1'b0; id_load = 1'b0; err_clr = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] v);
        id_load = 1'b1; id_wdata = v; step();
    endtask

    task automatic do_tx(input logic [1:0] na);
        node_act = na; tx_strobe = 1'b1; step(); step();
    endtask

    task automatic do_rx(input logic [7:0] v, input logic [1:0] na);
        node_act = na; rx_byte = v; rx_strobe = 1'b1; step(); step();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        m_id = 8'h00; m_err = 1'b0; m_send = 1'b0; m_recv = 1'b0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 id after reset", id_q, 8'h00);
        check("R1 err after reset", {7'd0, par_err}, 8'h00);
        check("R1 enables after reset", {6'd0, resp_send, resp_recv}, 8'h00);
        step();

        // R11 load, R2 protected transmit ignoring top bits
        do_load(8'hC5);
        check("R11 load", id_q, 8'hC5);
        check("R2 top bits ignored", tx_byte, ref_tx(8'h05, 1'b0));
        do_load(8'h3A);
        check("R2 protected byte", tx_byte, {ref_prot(8'h3A), 6'h3A});
        // R3 raw transmit
        par_off = 1'b1;
        do_load(8'hC5);
        check("R3 raw byte", tx_byte, 8'hC5);
        par_off = 1'b0;

        // R7 publish, R8 subscribe, R9 ignore codes on transmit
        node_act = 2'b00; tx_strobe = 1'b1; step();
        check("R7 send pulse", {7'd0, resp_send}, 8'd1);
        step();
        check("R7 send one cycle", {7'd0, resp_send}, 8'd0);
        do_tx(2'b01);
        do_tx(2'b10);
        do_tx(2'b11);

        // R4 protected receive, good parity
        do_rx(good_rx(6'h15), 2'b01);
        do_rx(good_rx(6'h2A), 2'b00);
        check("R4 stored", id_q, 8'h2A);
        // R6 bad parity sets flag, R8 suppresses receive
        rx_byte = good_rx(6'h11) ^ 8'h40; rx_strobe = 1'b1; node_act = 2'b01; step();
        check("R6 flag set", {7'd0, par_err}, 8'd1);
        check("R8 suppressed", {7'd0, resp_recv}, 8'd0);
        check("R4 top zero", id_q, 8'h11);
        step(); step();
        check("R6 sticky", {7'd0, par_err}, 8'd1);
        err_clr = 1'b1; step();
        check("R6 cleared", {7'd0, par_err}, 8'd0);
        // R6 set beats clear
        err_clr = 1'b1; rx_byte = 8'hFF ^ {ref_prot(8'h3F), 6'h00}; rx_strobe = 1'b1; step();
        check("R6 set wins", {7'd0, par_err}, 8'd1);
        err_clr = 1'b1; step();

        // R5 raw receive: all bits, no flag
        par_off = 1'b1;
        do_rx(good_rx(6'h09) ^ 8'hC0, 2'b01);
        check("R5 raw stored", id_q, good_rx(6'h09) ^ 8'hC0);
        check("R5 no flag", {7'd0, par_err}, 8'd0);
        par_off = 1'b0;

        // R10 coincident strobes and receive over load
        do_load(8'h07);
        tx_strobe = 1'b1; rx_strobe = 1'b1; rx_byte = 8'h00; node_act = 2'b01; step();
        check("R10 tx wins id", id_q, 8'h07);
        check("R10 no flag", {7'd0, par_err}, 8'd0);
        step();
        rx_strobe = 1'b1; rx_byte = good_rx(6'h1C); id_load = 1'b1; id_wdata = 8'h99; step();
        check("R10 rx over load", id_q, 8'h1C);
        step();

        // mixed traffic
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            r = $urandom;
            par_off   = r[0] & r[1];
            node_act  = r[3:2];
            tx_strobe = r[4] & r[5];
            rx_strobe = r[6];
            rx_byte   = r[7] ? good_rx(r[13:8]) : r[15:8];
            id_load   = r[16] & r[17];
            id_wdata  = r[25:18];
            err_clr   = r[26] & r[27] & r[28];
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule